// File: doc/BRIEF.md
# UART interrupt identification unit

This block sits beside the register file of a 16550-style serial port and decides which pending condition, if any, is reported to the processor. It combines the interrupt enable bits with the sticky line-error flags, the receive data-ready level, the receive FIFO fill count against the selected trigger level, a character-timeout level from the receive path and the sticky modem-status change flags. From these it forms the interrupt identification byte and a registered interrupt request.

The unit also owns the side effects of register accesses on those flags. The caller pulses one strobe per access: an identification read, an enable write, a holding-register write, a line-status read or a modem-status read. The transmit path pulses a drain strobe when the holding register or transmit FIFO empties, and a done strobe when the shifter goes idle. The FIFOs, the serial shifter and the baud generator sit outside the block. They feed it counts and levels.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, iir_o is 0x01, irq_o is 0, ier_o is 0, msr_delta_o is 0 and lsr_o is 0x60 (bit 6 shifter empty, bit 5 holding empty) while rx_ready_i is low.
- R2: The reported source follows a fixed priority, highest first: line error (low nibble 0x6), character timeout (0xC), receive data (0x4), transmit empty (0x2), modem change (0x0). When no source is active, the low nibble is 0x1.
- R3: The line error source is active when ier bit 2 is set and any of these lsr_o bits is set: bit 1 overrun, bit 2 parity, bit 3 framing, bit 4 break.
- R4: The character timeout source (rx_timeout_i) is reported only while ier bit 0 is set.
- R5: With fifo_en_i high, receive data needs ier bit 0, rx_ready_i and a rx_count_i at or above the trigger level. For a depth of 16, trig_sel_i 0, 1, 2 and 3 select 1, 4, 8 and 14. With fifo_en_i low, ier bit 0 and rx_ready_i are enough.
- R6: The transmit empty source needs ier bit 1 and the transmit pending flag. The modem change source needs ier bit 3 and any msr_delta_o bit.
- R7: An identification read while the low nibble is 0x2 clears the transmit pending flag. A read while another code is shown leaves it set.
- R8: An enable write that raises ier bit 1 while lsr_o bit 5 is 1 sets the pending flag. Rewriting bit 1 as 1 when it is already 1 does not. Raising it while bit 5 is 0 does not.
- R9: A holding-register write clears lsr_o bits 5 and 6 and the pending flag, and wins over a drain or done strobe in the same cycle. A drain strobe sets bit 5 and the pending flag when ier bit 1 is set. A done strobe sets bit 6.
- R10: A line-status read clears the overrun and break bits unless a set strobe for that bit arrives in the same cycle. The parity and framing bits follow par_err_i and frm_err_i. Bit 0 follows rx_ready_i.
- R11: A modem-status read clears all four delta bits unless a set strobe for a bit arrives in the same cycle.
- R12: iir_o bits 7:6 are 11 when fifo_en_i is high and 00 otherwise. Bits 5:4 are 0.
- R13: irq_o is high exactly when iir_o bit 0 was low one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_wr_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 4 | Enable write data: bit 0 rx data, 1 tx empty, 2 line error, 3 modem |
| iir_rd_i | input | 1 | Identification register read strobe |
| thr_wr_i | input | 1 | Holding register write strobe |
| lsr_rd_i | input | 1 | Line status read strobe |
| msr_rd_i | input | 1 | Modem status read strobe |
| ovr_set_i | input | 1 | Receive overrun event |
| brk_set_i | input | 1 | Break received event |
| par_err_i | input | 1 | Parity error of the head character |
| frm_err_i | input | 1 | Framing error of the head character |
| rx_ready_i | input | 1 | Receive data ready level |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| fifo_en_i | input | 1 | FIFO mode enabled |
| trig_sel_i | input | 2 | Receive trigger level select |
| rx_timeout_i | input | 1 | Character timeout pending level |
| tx_drain_i | input | 1 | Holding register or transmit FIFO drained |
| tx_done_i | input | 1 | Transmit shifter idle |
| msr_delta_set_i | input | 4 | Modem line change events |
| ier_o | output | 4 | Current enable register |
| lsr_o | output | 8 | Line status value |
| msr_delta_o | output | 4 | Sticky modem change bits |
| iir_o | output | 8 | Interrupt identification value |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach is the transmit pending flag differing from what the enable and holding-empty bits alone would predict. Examples are holding empty set with the flag already cleared by an identification read, or a higher source hiding the transmit code while the read arrives. The bench reaches these states by ordered strobe sequences. A drain is followed by a read, then the enable is rewritten with and without a rising edge. A line error is stacked on top so that the read lands on a different code. A sweep over all 16 enable values and all 32 source combinations, each started from a cleared state, checks the priority arithmetic.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_MSR  = 4'h0,
    ID_NONE = 4'h1,
    ID_THR  = 4'h2,
    ID_RDA  = 4'h4,
    ID_LSR  = 4'h6,
    ID_TMO  = 4'hC
  } irq_id_e;

  localparam int unsigned IER_RDA = 0;
  localparam int unsigned IER_THR = 1;
  localparam int unsigned IER_LSR = 2;
  localparam int unsigned IER_MSR = 3;
  localparam int unsigned MSR_DELTAS = 4;

  // receive trigger level scaled to the FIFO depth
  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;   // set wins over clear
      else if (clr_i)    q <= 1'b0;
    end
    assign q_o[i] = q;
  end

endmodule

// File: rtl/uart_irq_tx.sv
module uart_irq_tx
  import uart_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ier_wr_i,
  input  logic [3:0] ier_wdata_i,
  input  logic       thr_wr_i,
  input  logic       tx_drain_i,
  input  logic       tx_done_i,
  input  logic       iir_thr_rd_i,
  output logic [3:0] ier_o,
  output logic       thre_o,
  output logic       temt_o,
  output logic       pend_o
);

  logic [3:0] ier_q, ier_d;
  logic       thre_q, temt_q, pend_q, pend_d;

  always_comb begin
    ier_d  = ier_wr_i ? ier_wdata_i : ier_q;
    pend_d = pend_q;
    if (ier_wr_i && ier_wdata_i[IER_THR] && !ier_q[IER_THR] && thre_q) pend_d = 1'b1;
    if (iir_thr_rd_i) pend_d = 1'b0;
    if (tx_drain_i)   pend_d = 1'b1;
    if (thr_wr_i)     pend_d = 1'b0;
    if (!ier_d[IER_THR]) pend_d = 1'b0;  // flag only lives while enabled
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q  <= '0;
      thre_q <= 1'b1;
      temt_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      ier_q  <= ier_d;
      pend_q <= pend_d;
      if (thr_wr_i)        thre_q <= 1'b0;
      else if (tx_drain_i) thre_q <= 1'b1;
      if (thr_wr_i)        temt_q <= 1'b0;
      else if (tx_done_i)  temt_q <= 1'b1;
    end
  end

  assign ier_o  = ier_q;
  assign thre_o = thre_q;
  assign temt_o = temt_q;
  assign pend_o = pend_q;

  a_r9_thr_wr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> (!thre_q && !temt_q && !pend_q));

  a_r7_iir_rd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_thr_rd_i && !tx_drain_i && !ier_wr_i) |=> !pend_q);

  a_r8_no_rearm_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !thre_q && !tx_drain_i) |=> !pend_q);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       ier_i,
  input  logic             line_err_i,
  input  logic             rx_timeout_i,
  input  logic             rx_ready_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             fifo_en_i,
  input  logic [1:0]       trig_sel_i,
  input  logic             thr_pend_i,
  input  logic             msr_any_i,
  output logic [7:0]       iir_o,
  output logic             irq_o
);

  logic [CNT_W-1:0] lvl;
  logic             rda;
  irq_id_e          id;
  logic             irq_q;

  assign lvl = CNT_W'(trig_level(trig_sel_i, DEPTH));
  assign rda = rx_ready_i && (!fifo_en_i || (rx_count_i >= lvl));

  always_comb begin
    if (ier_i[IER_LSR] && line_err_i)        id = ID_LSR;
    else if (ier_i[IER_RDA] && rx_timeout_i) id = ID_TMO;
    else if (ier_i[IER_RDA] && rda)          id = ID_RDA;
    else if (ier_i[IER_THR] && thr_pend_i)   id = ID_THR;
    else if (ier_i[IER_MSR] && msr_any_i)    id = ID_MSR;
    else                                     id = ID_NONE;
  end

  assign iir_o = {fifo_en_i ? 2'b11 : 2'b00, 2'b00, id};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (id != ID_NONE);
  end

  assign irq_o = irq_q;

  a_r4_tmo_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ier_i[IER_RDA] |-> (id != ID_TMO && id != ID_RDA));

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ier_wr_i,
  input  logic [3:0]       ier_wdata_i,
  input  logic             iir_rd_i,
  input  logic             thr_wr_i,
  input  logic             lsr_rd_i,
  input  logic             msr_rd_i,
  input  logic             ovr_set_i,
  input  logic             brk_set_i,
  input  logic             par_err_i,
  input  logic             frm_err_i,
  input  logic             rx_ready_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             fifo_en_i,
  input  logic [1:0]       trig_sel_i,
  input  logic             rx_timeout_i,
  input  logic             tx_drain_i,
  input  logic             tx_done_i,
  input  logic [3:0]       msr_delta_set_i,
  output logic [3:0]       ier_o,
  output logic [7:0]       lsr_o,
  output logic [3:0]       msr_delta_o,
  output logic [7:0]       iir_o,
  output logic             irq_o
);

  logic [1:0]            err_q;   // {break, overrun}
  logic [MSR_DELTAS-1:0] delta_q;
  logic                  thre, temt, thr_pend, iir_thr_rd, line_err;

  uart_irq_sticky #(.W(2)) u_lsr_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({brk_set_i, ovr_set_i}),
    .clr_i  (lsr_rd_i),
    .q_o    (err_q)
  );

  uart_irq_sticky #(.W(MSR_DELTAS)) u_msr_delta (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (msr_delta_set_i),
    .clr_i  (msr_rd_i),
    .q_o    (delta_q)
  );

  assign iir_thr_rd = iir_rd_i && (iir_o[3:0] == ID_THR);

  uart_irq_tx u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ier_wr_i     (ier_wr_i),
    .ier_wdata_i  (ier_wdata_i),
    .thr_wr_i     (thr_wr_i),
    .tx_drain_i   (tx_drain_i),
    .tx_done_i    (tx_done_i),
    .iir_thr_rd_i (iir_thr_rd),
    .ier_o        (ier_o),
    .thre_o       (thre),
    .temt_o       (temt),
    .pend_o       (thr_pend)
  );

  assign lsr_o    = {1'b0, temt, thre, err_q[1], frm_err_i, par_err_i, err_q[0], rx_ready_i};
  assign line_err = |lsr_o[4:1];

  uart_irq_prio #(.DEPTH(DEPTH)) u_prio (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ier_i        (ier_o),
    .line_err_i   (line_err),
    .rx_timeout_i (rx_timeout_i),
    .rx_ready_i   (rx_ready_i),
    .rx_count_i   (rx_count_i),
    .fifo_en_i    (fifo_en_i),
    .trig_sel_i   (trig_sel_i),
    .thr_pend_i   (thr_pend),
    .msr_any_i    (|delta_q),
    .iir_o        (iir_o),
    .irq_o        (irq_o)
  );

  assign msr_delta_o = delta_q;

  a_r10_lsr_rd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !ovr_set_i && !brk_set_i) |=> (!lsr_o[1] && !lsr_o[4]));

  a_r11_msr_rd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_rd_i && msr_delta_set_i == '0) |=> (msr_delta_o == '0));

  a_r13_irq_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_o[0] && !irq_o) |=> !irq_o);

endmodule

// File: tb/uart_irq_ident_tb.sv
`timescale 1ns/1ps
module uart_irq_ident_tb_top;

  localparam int unsigned DEPTH = 16;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             ier_wr_i = 0, iir_rd_i = 0, thr_wr_i = 0, lsr_rd_i = 0, msr_rd_i = 0;
  logic [3:0]       ier_wdata_i = 0;
  logic             ovr_set_i = 0, brk_set_i = 0, par_err_i = 0, frm_err_i = 0;
  logic             rx_ready_i = 0, fifo_en_i = 0, rx_timeout_i = 0, tx_drain_i = 0, tx_done_i = 0;
  logic [CNT_W-1:0] rx_count_i = 0;
  logic [1:0]       trig_sel_i = 0;
  logic [3:0]       msr_delta_set_i = 0;
  logic [3:0]       ier_o, msr_delta_o;
  logic [7:0]       lsr_o, iir_o;
  logic             irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  uart_irq_ident #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle clearing every sticky source and writing the enable register
  task automatic clean(input logic [3:0] e);
    ier_wr_i = 1; ier_wdata_i = e; lsr_rd_i = 1; msr_rd_i = 1; thr_wr_i = 1;
    rx_ready_i = 0; rx_timeout_i = 0; par_err_i = 0; frm_err_i = 0;
    step();
    ier_wr_i = 0; lsr_rd_i = 0; msr_rd_i = 0; thr_wr_i = 0;
  endtask

  task automatic pulse_done();
    step();
    ier_wr_i = 0; iir_rd_i = 0; thr_wr_i = 0; lsr_rd_i = 0; msr_rd_i = 0;
    ovr_set_i = 0; brk_set_i = 0; tx_drain_i = 0; tx_done_i = 0; msr_delta_set_i = 0;
  endtask

  function automatic logic [7:0] prio_code(input logic [3:0] e, input logic [4:0] s);
    if (e[2] && s[4])      return 8'h06;
    else if (e[0] && s[3]) return 8'h0C;
    else if (e[0] && s[2]) return 8'h04;
    else if (e[1] && s[1]) return 8'h02;
    else if (e[3] && s[0]) return 8'h00;
    else                   return 8'h01;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_ni = 1;
    step();
    // R1 reset state
    chk("R1 iir", iir_o, 8'h01);
    chk("R1 irq", irq_o, 0);
    chk("R1 lsr", lsr_o, 8'h60);
    chk("R1 ier", ier_o, 0);
    chk("R1 delta", msr_delta_o, 0);

    // R2 / R13 sweep: every enable value against every source combination
    for (int e = 0; e < 16; e++) begin
      for (int s = 0; s < 32; s++) begin
        logic [7:0] exp;
        clean(4'(e));
        ovr_set_i = s[4]; rx_timeout_i = s[3]; rx_ready_i = s[2];
        tx_drain_i = s[1]; msr_delta_set_i = s[0] ? 4'b0001 : 4'b0000;
        pulse_done();
        exp = prio_code(4'(e), 5'(s));
        chk("R2 sweep", iir_o, exp);
        step();
        chk("R13 sweep", irq_o, exp != 8'h01);
      end
    end

    // R3 each line error bit
    for (int b = 0; b < 4; b++) begin
      clean(4'h4);
      case (b)
        0: ovr_set_i = 1;
        1: par_err_i = 1;
        2: frm_err_i = 1;
        default: brk_set_i = 1;
      endcase
      pulse_done();
      chk("R3 code", iir_o, 8'h06);
      chk("R3 lsr", lsr_o, 32'(1) << (b + 1));
      par_err_i = 0; frm_err_i = 0; lsr_rd_i = 1;
      pulse_done();
      chk("R3 cleared", iir_o, 8'h01);
    end

    // R4 timeout gated by rx data enable
    clean(4'h4);
    rx_timeout_i = 1;
    step();
    chk("R4 gated", iir_o, 8'h01);
    ier_wr_i = 1; ier_wdata_i = 4'h1;
    pulse_done();
    chk("R4 enabled", iir_o, 8'h0C);
    rx_timeout_i = 0;

    // R5 / R12 FIFO trigger sweep
    clean(4'h1);
    fifo_en_i = 1; rx_ready_i = 1;
    for (int t = 0; t < 4; t++) begin
      for (int c = 0; c <= 16; c++) begin
        int lvl;
        lvl = (t == 0) ? 1 : (t == 1) ? DEPTH / 4 : (t == 2) ? DEPTH / 2 : DEPTH - 2;
        trig_sel_i = 2'(t); rx_count_i = CNT_W'(c);
        step();
        chk("R5 trigger", iir_o, (c >= lvl) ? 8'hC4 : 8'hC1);
      end
    end
    rx_ready_i = 0; rx_count_i = CNT_W'(16);
    step();
    chk("R5 not ready", iir_o, 8'hC1);
    fifo_en_i = 0; rx_ready_i = 1; rx_count_i = 0;
    step();
    chk("R12 fifo off", iir_o, 8'h04);
    rx_ready_i = 0;

    // R6 / R7 identification read clears the transmit flag
    clean(4'h2);
    tx_drain_i = 1;
    pulse_done();
    chk("R6 thr code", iir_o, 8'h02);
    iir_rd_i = 1;
    pulse_done();
    chk("R7 read clears", iir_o, 8'h01);
    ier_wr_i = 1; ier_wdata_i = 4'h6; ovr_set_i = 1; tx_drain_i = 1;
    pulse_done();
    chk("R7 lsr above", iir_o, 8'h06);
    iir_rd_i = 1;
    pulse_done();
    lsr_rd_i = 1;
    pulse_done();
    chk("R7 other code kept", iir_o, 8'h02);

    // R8 re-arm on rising enable
    iir_rd_i = 1;
    pulse_done();
    chk("R8 cleared", iir_o, 8'h01);
    ier_wr_i = 1; ier_wdata_i = 4'h6;
    pulse_done();
    chk("R8 no rearm 1->1", iir_o, 8'h01);
    ier_wr_i = 1; ier_wdata_i = 4'h4;
    pulse_done();
    ier_wr_i = 1; ier_wdata_i = 4'h6;
    pulse_done();
    chk("R8 rearm", iir_o, 8'h02);
    thr_wr_i = 1;
    pulse_done();
    ier_wr_i = 1; ier_wdata_i = 4'h4;
    pulse_done();
    ier_wr_i = 1; ier_wdata_i = 4'h6;
    pulse_done();
    chk("R8 no rearm thre0", iir_o, 8'h01);

    // R9 holding write, drain, done
    chk("R9 lsr after write", lsr_o, 8'h00);
    tx_drain_i = 1;
    pulse_done();
    chk("R9 drain lsr", lsr_o, 8'h20);
    chk("R9 drain code", iir_o, 8'h02);
    tx_done_i = 1;
    pulse_done();
    chk("R9 done lsr", lsr_o, 8'h60);
    thr_wr_i = 1; tx_drain_i = 1; tx_done_i = 1;
    pulse_done();
    chk("R9 write wins lsr", lsr_o, 8'h00);
    chk("R9 write wins code", iir_o, 8'h01);

    // R10 line status read
    ovr_set_i = 1; brk_set_i = 1; par_err_i = 1; frm_err_i = 1;
    pulse_done();
    chk("R10 all set", lsr_o, 8'h1E);
    lsr_rd_i = 1;
    pulse_done();
    chk("R10 read clears", lsr_o, 8'h0C);
    lsr_rd_i = 1; ovr_set_i = 1;
    pulse_done();
    chk("R10 set wins", lsr_o, 8'h0E);
    par_err_i = 0; frm_err_i = 0; lsr_rd_i = 1;
    pulse_done();
    chk("R10 empty", lsr_o, 8'h00);

    // R11 / R13 modem status
    clean(4'h8);
    msr_delta_set_i = 4'b1010;
    pulse_done();
    chk("R11 deltas", msr_delta_o, 4'b1010);
    chk("R6 msr code", iir_o, 8'h00);
    step();
    chk("R13 irq high", irq_o, 1);
    msr_rd_i = 1;
    pulse_done();
    chk("R11 read clears", msr_delta_o, 4'b0000);
    chk("R11 code", iir_o, 8'h01);
    chk("R13 irq lags", irq_o, 1);
    step();
    chk("R13 irq low", irq_o, 0);
    msr_rd_i = 1; msr_delta_set_i = 4'b0001;
    pulse_done();
    chk("R11 set wins", msr_delta_o, 4'b0001);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule